// File: doc/BRIEF.md
# DMX512 Slot Receiver with Threshold Outputs

This block listens to the receive line of an RS-485 transceiver carrying a DMX512 lighting stream. It resynchronises the line to the system clock, recognises the long low level that opens every packet, and deserialises the 250 kbaud frames that follow. Each accepted frame advances a slot counter, so every byte is known by its position in the packet.

Four channel outputs sit on consecutive slots just above a base address supplied at the port. When the byte for a channel's slot arrives, the output goes high if the byte is above the halfway value and low otherwise. It then holds that level until the same slot is received again. Slot 0 carries the start code and never drives a channel. A frame with a bad stop bit is dropped, and the packet is ignored from that point until the next break.

Top module: `dmx_slot_rx`

## Requirements
- R1: A bit lasts CLK_PER_BIT clock cycles (default 32, i.e. 250 kbaud at 8 MHz). A frame is one low start bit, then 8 data bits sent least significant bit first, then two high stop bits.
- R2: The line passes through a two-flop synchronizer. A start bit is only accepted if the line is still low half a bit period after the falling edge, so a low pulse shorter than half a bit is ignored. Each later bit is sampled at its mid-point.
- R3: A break is a low level lasting at least BREAK_BITS bit times (default 22, i.e. 704 cycles). `break_det` pulses high for exactly one cycle shortly after the line returns high. A low level of 21 bit times gives no pulse.
- R4: A break sets the slot counter to 0 and re-enables reception. The byte in slot 0 (the start code) never changes any channel output.
- R5: Each correctly framed byte received while reception is enabled advances the slot counter by one. Channel k (k = 0..3, `ch_out[k]`) takes its value from slot `base_addr + 1 + k`.
- R6: A channel's new level is 1 when the byte is 128 or more and 0 when it is 127 or less.
- R7: A low level where either stop bit is expected gives a one-cycle `frame_err` pulse and drops the frame. Reception is then disabled until the next break. The start of a break of 10 or more bit times also produces this pulse. `frame_err` never coincides with an accepted byte.
- R8: After reset every channel output is 0. A channel keeps its level across packets in which its slot is absent, and also after a framing error.
- R9: After reset, reception stays disabled until the first break. Correctly framed bytes sent before that break change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (8 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial receive line, idle high, asynchronous |
| base_addr | input | ADDR_W (9) | Base slot address; channel k uses slot base_addr+1+k |
| ch_out | output | NUM_CH (4) | Thresholded channel levels |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |
| break_det | output | 1 | One-cycle pulse when a break ends |

## Verification
Two events land in the same clock cycle when the line rises after a break. In that cycle the break detector reports the break, and the deserializer leaves its wait-for-high state and re-arms for the next start bit. The bench provokes this with the shortest mark-after-break it uses (12 cycles) and with a sub-half-bit glitch inside that mark. The outcome is judged by whether the start code still lands in slot 0, which shows in whether channel 0 follows the byte of slot `base_addr+1` rather than the start code. The bench also sends breaks of exactly 22 and of 21 bit times. After a mid-packet framing error it checks that no later byte of that packet reaches an output.

// File: rtl/dmx_rx_pkg.sv
package dmx_rx_pkg;

  // Slot counter width: covers start code plus 512 data slots.
  localparam int DMX_SLOT_W = 10;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP1,
    RX_STOP2,
    RX_WAIT_HI
  } rx_state_e;

  // Slot index feeding channel k for a given base address.
  function automatic logic [DMX_SLOT_W-1:0] chan_slot(
    input logic [DMX_SLOT_W-1:0] base,
    input int unsigned           k
  );
    return base + DMX_SLOT_W'(k) + DMX_SLOT_W'(1);
  endfunction

  // Channel level from a captured byte.
  function automatic logic above_thresh(input logic [7:0] b, input logic [7:0] th);
    return b > th;
  endfunction

  // Saturating increment of the slot counter.
  function automatic logic [DMX_SLOT_W-1:0] slot_next(input logic [DMX_SLOT_W-1:0] s);
    return (s == {DMX_SLOT_W{1'b1}}) ? s : s + DMX_SLOT_W'(1);
  endfunction

endpackage

// File: rtl/dmx_rx_sync.sv
module dmx_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/dmx_break_det.sv
module dmx_break_det #(
  parameter int CLK_PER_BIT = 32,
  parameter int BREAK_BITS  = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic brk_pulse
);
  localparam int BRK_CYC = CLK_PER_BIT * BREAK_BITS;
  localparam int CNT_W   = $clog2(BRK_CYC + 1);

  logic [CNT_W-1:0] low_cnt;
  logic             long_low;

  assign long_low = (low_cnt >= CNT_W'(BRK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      brk_pulse <= 1'b0;
    end else begin
      // The count is nonzero only while the line has been low, so a high
      // line with a long count marks the release edge of a break.
      brk_pulse <= line && long_low;
      if (line)           low_cnt <= '0;
      else if (!long_low) low_cnt <= low_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dmx_uart_rx.sv
module dmx_uart_rx
  import dmx_rx_pkg::*;
#(
  parameter int CLK_PER_BIT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       ferr
);
  localparam int TMR_W = $clog2(CLK_PER_BIT);
  localparam int HALF  = CLK_PER_BIT / 2;

  rx_state_e        state;
  logic [TMR_W-1:0] tmr;
  logic [2:0]       bitn;
  logic [7:0]       shreg;
  logic             tick;

  assign tick      = (tmr == '0);
  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      tmr      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      ferr     <= 1'b0;
      if (!tick) tmr <= tmr - TMR_W'(1);
      unique case (state)
        RX_IDLE: begin
          if (!line) begin
            state <= RX_START;
            tmr   <= TMR_W'(HALF - 1);
          end
        end
        RX_START: begin
          if (tick) begin
            if (!line) begin
              state <= RX_DATA;
              tmr   <= TMR_W'(CLK_PER_BIT - 1);
              bitn  <= '0;
            end else begin
              state <= RX_IDLE;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            shreg <= {line, shreg[7:1]};
            tmr   <= TMR_W'(CLK_PER_BIT - 1);
            if (bitn == 3'd7) state <= RX_STOP1;
            else              bitn  <= bitn + 3'd1;
          end
        end
        RX_STOP1: begin
          if (tick) begin
            if (line) begin
              state <= RX_STOP2;
              tmr   <= TMR_W'(CLK_PER_BIT - 1);
            end else begin
              ferr  <= 1'b1;
              state <= RX_WAIT_HI;
            end
          end
        end
        RX_STOP2: begin
          if (tick) begin
            if (line) begin
              byte_vld <= 1'b1;
              state    <= RX_IDLE;
            end else begin
              ferr  <= 1'b1;
              state <= RX_WAIT_HI;
            end
          end
        end
        RX_WAIT_HI: begin
          if (line) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmx_slot_map.sv
module dmx_slot_map
  import dmx_rx_pkg::*;
#(
  parameter int         NUM_CH = 4,
  parameter int         ADDR_W = 9,
  parameter logic [7:0] THRESH = 8'd127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk,
  input  logic              ferr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              byte_take,
  output logic              hold,
  output logic [DMX_SLOT_W-1:0] slot_cnt,
  output logic [NUM_CH-1:0] ch_out
);
  localparam int SLOT_W = DMX_SLOT_W;

  logic [SLOT_W-1:0] base_ext;

  assign base_ext  = {{(SLOT_W-ADDR_W){1'b0}}, base_addr};
  // A break in the same cycle wins over a byte.
  assign byte_take = byte_vld && !hold && !brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      hold     <= 1'b1;
    end else if (brk) begin
      slot_cnt <= '0;
      hold     <= 1'b0;
    end else if (ferr) begin
      hold     <= 1'b1;
    end else if (byte_take) begin
      slot_cnt <= slot_next(slot_cnt);
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic hit;
    assign hit = byte_take && (slot_cnt == chan_slot(base_ext, k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ch_out[k] <= 1'b0;
      else if (hit) ch_out[k] <= above_thresh(byte_data, THRESH);
    end
  end
endmodule

// File: rtl/dmx_slot_rx.sv
module dmx_slot_rx
  import dmx_rx_pkg::*;
#(
  parameter int         CLK_PER_BIT = 32,
  parameter int         BREAK_BITS  = 22,
  parameter int         NUM_CH      = 4,
  parameter int         ADDR_W      = 9,
  parameter logic [7:0] THRESH      = 8'd127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [NUM_CH-1:0] ch_out,
  output logic              frame_err,
  output logic              break_det
);
  localparam int SLOT_W = DMX_SLOT_W;

  // Internal events brought out by name for the checker.
  logic              rx_s;
  logic              byte_vld;
  logic [7:0]        byte_data;
  logic              byte_take;
  logic              hold;
  logic [SLOT_W-1:0] slot_cnt;

  dmx_rx_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rx_in),
    .d_sync  (rx_s)
  );

  dmx_break_det #(.CLK_PER_BIT(CLK_PER_BIT), .BREAK_BITS(BREAK_BITS)) u_brk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line      (rx_s),
    .brk_pulse (break_det)
  );

  dmx_uart_rx #(.CLK_PER_BIT(CLK_PER_BIT)) u_uart (
    .clk       (clk),
    .rst_n     (rst_n),
    .line      (rx_s),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .ferr      (frame_err)
  );

  dmx_slot_map #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .THRESH(THRESH)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk       (break_det),
    .ferr      (frame_err),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .base_addr (base_addr),
    .byte_take (byte_take),
    .hold      (hold),
    .slot_cnt  (slot_cnt),
    .ch_out    (ch_out)
  );
endmodule

// File: rtl/dmx_slot_rx_chk.sv
module dmx_slot_rx_chk #(
  parameter int NUM_CH = 4,
  parameter int SLOT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_out,
  input logic              frame_err,
  input logic              break_det,
  input logic              byte_vld,
  input logic              byte_take,
  input logic              hold,
  input logic [SLOT_W-1:0] slot_cnt
);
  logic got_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         got_brk <= 1'b0;
    else if (break_det) got_brk <= 1'b1;
  end

  assert_brk_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |=> !break_det);

  assert_brk_slot0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |=> (slot_cnt == '0 && !hold));

  assert_slot_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && slot_cnt != '1) |=> slot_cnt == SLOT_W'($past(slot_cnt) + 1'b1));

  assert_ferr_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !break_det) |=> hold);

  assert_ferr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && byte_vld));

  assert_ch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_take |=> $stable(ch_out));

  assert_quiet_before_brk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !got_brk |-> ch_out == '0);
endmodule

bind dmx_slot_rx dmx_slot_rx_chk #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_out    (ch_out),
  .frame_err (frame_err),
  .break_det (break_det),
  .byte_vld  (byte_vld),
  .byte_take (byte_take),
  .hold      (hold),
  .slot_cnt  (slot_cnt)
);

// File: tb/dmx_slot_rx_bench.sv
module dmx_slot_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 32;
  localparam int NCH        = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic [8:0] base_addr = '0;
  logic [3:0] ch_out;
  logic       frame_err;
  logic       break_det;

  int n_chk = 0;
  int n_bad = 0;
  int brk_seen = 0;
  int ferr_seen = 0;

  // Reference model state
  logic [3:0] exp_ch = '0;
  int  exp_brk = 0;
  int  exp_ferr = 0;
  bit  armed = 0;
  int  mslot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmx_slot_rx u_dmx_slot_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_in     (rx_in),
    .base_addr (base_addr),
    .ch_out    (ch_out),
    .frame_err (frame_err),
    .break_det (break_det)
  );

  always @(posedge clk) begin
    if (rst_n && break_det) brk_seen++;
    if (rst_n && frame_err) ferr_seen++;
  end

  function automatic logic level_of(input logic [7:0] b);
    return b[7];  // 128..255 -> 1, 0..127 -> 0
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle(input int cycles);
    rx_in = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit bad);
    rx_in = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx_in = !bad;
    repeat (CPB) @(negedge clk);
    rx_in = 1'b1;
    repeat (CPB) @(negedge clk);
    if (bad) begin
      exp_ferr++;
      armed = 0;
    end else if (armed) begin
      for (int k = 0; k < NCH; k++)
        if (mslot == int'(base_addr) + 1 + k) exp_ch[k] = level_of(b);
      mslot++;
    end
  endtask

  task automatic send_break(input int bits, input int mab);
    rx_in = 1'b0;
    repeat (bits * CPB) @(negedge clk);
    rx_in = 1'b1;
    repeat (mab) @(negedge clk);
    if (bits >= 10) exp_ferr++;
    if (bits >= 22) begin
      exp_brk++;
      armed = 1;
      mslot = 0;
    end else begin
      armed = 0;
    end
  endtask

  task automatic check_all(input string tag);
    idle(8);
    check({tag, " ch_out"}, 32'(ch_out), 32'(exp_ch));
    check({tag, " break count"}, 32'(brk_seen), 32'(exp_brk));
    check({tag, " frame_err count"}, 32'(ferr_seen), 32'(exp_ferr));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R8: reset state
    check("R8 reset ch_out", 32'(ch_out), 32'h0);
    check("R3 reset break_det", 32'(break_det), 32'h0);
    rst_n = 1'b1;
    idle(10);

    // R9: bytes before the first break change nothing
    base_addr = 9'd0;
    for (int i = 0; i < 6; i++) send_byte(8'hFF, 0);
    check_all("R9");

    // R3 exact 22-bit break, R2 glitch in a short mark, R4 start code, R6 thresholds
    send_break(22, 12);
    rx_in = 1'b0;
    repeat (6) @(negedge clk);
    idle(20);
    send_byte(8'hFF, 0);         // start code, slot 0
    send_byte(8'd128, 0);        // slot 1 -> ch0
    send_byte(8'd127, 0);        // slot 2 -> ch1
    send_byte(8'd255, 0);        // slot 3 -> ch2
    send_byte(8'd0, 0);          // slot 4 -> ch3
    check_all("R4 R5 R6 R2 R3");
    check("R6 exact levels", 32'(ch_out), 32'b0101);

    // R8: short packet, only slot 1 present
    send_break(30, 40);
    send_byte(8'h00, 0);
    send_byte(8'h10, 0);
    check_all("R8 short packet");
    check("R8 held channels", 32'(ch_out), 32'b0100);

    // R7: framing error mid-packet freezes the rest
    send_break(25, 32);
    send_byte(8'h00, 0);
    send_byte(8'hC0, 0);         // slot 1 -> ch0 = 1
    send_byte(8'hFF, 1);         // bad stop bit
    send_byte(8'hFF, 0);
    send_byte(8'hFF, 0);
    send_byte(8'hFF, 0);
    check_all("R7 frame error");
    check("R7 frozen channels", 32'(ch_out), 32'b0101);

    // R3: 21-bit low is not a break
    send_break(21, 40);
    send_byte(8'h00, 0);
    send_byte(8'h00, 0);
    send_byte(8'h00, 0);
    check_all("R3 short low");

    // R5 with nonzero base
    base_addr = 9'd5;
    send_break(22, 16);
    for (int s = 0; s <= 9; s++) send_byte((s >= 6) ? 8'h80 : 8'h00, 0);
    check_all("R5 base 5");
    check("R5 base 5 levels", 32'(ch_out), 32'b1111);

    // Random packets
    for (int p = 0; p < 8; p++) begin
      int len;
      base_addr = 9'($urandom_range(0, 12));
      len = $urandom_range(1, 19);
      send_break($urandom_range(22, 40), $urandom_range(12, 64));
      send_byte(8'($urandom_range(0, 255)), 0);
      for (int s = 0; s < len; s++)
        send_byte(8'($urandom_range(0, 255)), ($urandom_range(0, 15) == 0));
      check_all($sformatf("R5 R6 R7 random packet %0d", p));
    end

    finish_run();
  end
endmodule